// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits behind the bit-level receiver of a single-wire consumer-control bus. For every frame it looks at the first byte (the header), pulls out the sender and target logical addresses, and decides two things that hold for the whole frame. The first is whether the frame is handed on for storage. The second is whether the node pulls the line low in the acknowledge slot that follows each block. The decision is captured once, when the header arrives. It stays fixed until the acknowledge slot of the block flagged as the end of the message has passed.

The node can own several logical addresses at the same time. These are given as a 15-bit bitmask with one bit per address. Target address 15 is the broadcast address. A mode input chooses between two filters. The reduced filter keeps only frames that concern the node. The full filter also keeps frames meant for other nodes, but stays silent on the line for them. A broadcast frame is always kept and never acknowledged low, because on a broadcast a low acknowledge signals rejection.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `accept`, `ack_drive` and `bcast` are 0 and `init_addr` and `dest_addr` are 0.
- R2: A header block is a cycle with `blk_valid` and `blk_hdr` both high. Its sender address is `blk_byte[7:4]` and its target address is `blk_byte[3:0]`. These appear on `init_addr` and `dest_addr` from the clock edge that captures the header and stay unchanged until the frame closes.
- R3: Bit k of `own_mask` (k = 0..14) makes the node own logical address k. Any number of bits may be set at once, and a mask of zero owns no address.
- R4: With `listen_all` = 0, `accept` goes to 1 only for a frame whose target is owned or is 15.
- R5: With `listen_all` = 1, every frame is accepted. A frame to a target that is not owned gets no acknowledge.
- R6: A frame with target 15 sets `bcast` and `accept` to 1 in both modes, and `ack_drive` stays 0 for the whole frame.
- R7: For a frame to an owned target, `ack_drive` is 1 in the same cycle as `ack_slot` in the acknowledge slot of every block, the header block included, and 0 whenever `ack_slot` is 0.
- R8: A block with `blk_eom` = 1 is the last block. The frame closes at the clock edge where `ack_slot` is seen falling after that block, and `accept`, `bcast` and the addresses return to 0. If `blk_eom` is set on the header, the frame is a header-only ping and is handled the same way. Before that point the frame stays open.
- R9: `own_mask` and `listen_all` are captured with the header. Changing them while a frame is open has no effect on that frame's `accept` or `ack_drive`.
- R10: A new header that arrives while a frame is still open starts a new decision from the new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | One-cycle strobe: a received block is available |
| blk_hdr | input | 1 | The strobed block is a frame header |
| blk_eom | input | 1 | The strobed block is the last of the frame |
| blk_byte | input | 8 | Received block byte |
| ack_slot | input | 1 | High during the acknowledge bit of the current block |
| own_mask | input | 15 | One bit per owned logical address |
| listen_all | input | 1 | 1 selects the full filter, 0 the reduced filter |
| accept | output | 1 | The current frame is to be stored |
| ack_drive | output | 1 | Request to drive the acknowledge bit low now |
| bcast | output | 1 | The current frame is a broadcast |
| init_addr | output | 4 | Sender address of the current frame |
| dest_addr | output | 4 | Target address of the current frame |

## Verification
The vector table covers the mask edges: address 0, address 14, a zero mask, several bits set at once, and a full mask with the target set to 15. A design that indexed the mask off by one, or that treated 15 as an owned address, would accept or acknowledge the wrong frames. Directed tests change the mode and the mask in the middle of a frame, and a design that decides per block would then flip `accept` or `ack_drive` halfway through. Other tests send a second header before the end of the message, and a design that ignores it would keep the stale target. A multi-block frame checks that the acknowledge request repeats in every slot and that the frame does not close before the last block.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;

  localparam int ADDR_W   = 4;
  localparam int N_OWN    = (1 << ADDR_W) - 1;
  localparam int BYTE_W   = 2 * ADDR_W;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = {ADDR_W{1'b1}};

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [N_OWN-1:0]  mask_t;

  typedef struct packed {
    addr_t init;
    addr_t dest;
  } hdr_t;

  typedef struct packed {
    logic accept;
    logic ack_en;
    logic bcast;
  } verdict_t;

  function automatic logic is_bcast(input addr_t a);
    return a == BCAST_ADDR;
  endfunction

  function automatic logic addr_owned(input addr_t a, input mask_t m);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < N_OWN; k++) begin
      if (a == addr_t'(k) && m[k]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic verdict_t judge(input addr_t dest, input mask_t m,
                                     input logic listen);
    verdict_t v;
    logic bc;
    logic own;
    bc       = is_bcast(dest);
    own      = addr_owned(dest, m);
    v.bcast  = bc;
    v.ack_en = own & ~bc;
    v.accept = bc | own | listen;
    return v;
  endfunction

endpackage

// File: rtl/rx_filt_frame.sv
module rx_filt_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_valid,
  input  logic blk_hdr,
  input  logic blk_eom,
  input  logic ack_slot,
  output logic frame_open,
  output logic hdr_evt,
  output logic close_evt
);

  logic last_q;
  logic slot_q;
  logic slot_fall;

  assign hdr_evt   = blk_valid & blk_hdr;
  assign slot_fall = slot_q & ~ack_slot;
  assign close_evt = frame_open & last_q & slot_fall & ~hdr_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_open <= 1'b0;
      last_q     <= 1'b0;
      slot_q     <= 1'b0;
    end else begin
      slot_q <= ack_slot;
      if (hdr_evt) begin
        frame_open <= 1'b1;
        last_q     <= blk_eom;
      end else if (close_evt) begin
        frame_open <= 1'b0;
        last_q     <= 1'b0;
      end else if (frame_open && blk_valid && blk_eom) begin
        last_q <= 1'b1;
      end
    end
  end

  // R8: without an end-of-message mark the frame never closes
  a_r8_no_early_close: assert property (@(posedge clk) disable iff (!rst_n)
    frame_open && !last_q && !(blk_valid && blk_eom) |=> frame_open);

  // R10: a header always leaves the frame open
  a_r10_hdr_opens: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_evt |=> frame_open);

endmodule

// File: rtl/rx_filt_verdict.sv
module rx_filt_verdict
  import rx_filt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hdr_evt,
  input  logic               close_evt,
  input  logic [BYTE_W-1:0]  hdr_byte,
  input  mask_t              own_mask,
  input  logic               listen_all,
  output logic               accept,
  output logic               ack_en,
  output logic               bcast,
  output addr_t              init_addr,
  output addr_t              dest_addr
);

  hdr_t     hdr;
  verdict_t next_v;

  always_comb begin
    hdr    = hdr_t'(hdr_byte);
    next_v = judge(hdr.dest, own_mask, listen_all);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept    <= 1'b0;
      ack_en    <= 1'b0;
      bcast     <= 1'b0;
      init_addr <= '0;
      dest_addr <= '0;
    end else if (hdr_evt) begin
      accept    <= next_v.accept;
      ack_en    <= next_v.ack_en;
      bcast     <= next_v.bcast;
      init_addr <= hdr.init;
      dest_addr <= hdr.dest;
    end else if (close_evt) begin
      accept    <= 1'b0;
      ack_en    <= 1'b0;
      bcast     <= 1'b0;
      init_addr <= '0;
      dest_addr <= '0;
    end
  end

  // R2: fields held between header and close
  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_evt && !close_evt |=> $stable(dest_addr) && $stable(init_addr));

  // R3: zero mask in reduced mode owns nothing
  a_r3_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_evt && own_mask == '0 && !listen_all && hdr_byte[ADDR_W-1:0] != BCAST_ADDR
    |=> !accept);

  // R5: acknowledge only for accepted frames
  a_r5_ack_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |-> accept);

  // R6: broadcast target is accepted and never acknowledged low
  a_r6_bcast_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_evt && hdr_byte[ADDR_W-1:0] == BCAST_ADDR |=> accept && bcast && !ack_en);

  // R9: decision fixed while no new header arrives
  a_r9_verdict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_evt && !close_evt |=> $stable(accept) && $stable(ack_en));

endmodule

// File: rtl/rx_filt_ack.sv
module rx_filt_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_open,
  input  logic ack_en,
  input  logic ack_slot,
  output logic ack_drive
);

  assign ack_drive = frame_open & ack_en & ack_slot;

  // R7: no request outside the acknowledge slot
  a_r7_only_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_slot |-> !ack_drive);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int AW    = ADDR_W,
  localparam int MW   = (1 << AW) - 1,
  localparam int BW   = 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_valid,
  input  logic          blk_hdr,
  input  logic          blk_eom,
  input  logic [BW-1:0] blk_byte,
  input  logic          ack_slot,
  input  logic [MW-1:0] own_mask,
  input  logic          listen_all,
  output logic          accept,
  output logic          ack_drive,
  output logic          bcast,
  output logic [AW-1:0] init_addr,
  output logic [AW-1:0] dest_addr
);

  logic frame_open;
  logic hdr_evt;
  logic close_evt;
  logic ack_en;

  initial begin
    a_width_match: assert (AW == ADDR_W);
  end

  rx_filt_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_valid  (blk_valid),
    .blk_hdr    (blk_hdr),
    .blk_eom    (blk_eom),
    .ack_slot   (ack_slot),
    .frame_open (frame_open),
    .hdr_evt    (hdr_evt),
    .close_evt  (close_evt)
  );

  rx_filt_verdict u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_evt    (hdr_evt),
    .close_evt  (close_evt),
    .hdr_byte   (blk_byte),
    .own_mask   (own_mask),
    .listen_all (listen_all),
    .accept     (accept),
    .ack_en     (ack_en),
    .bcast      (bcast),
    .init_addr  (init_addr),
    .dest_addr  (dest_addr)
  );

  rx_filt_ack u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_open (frame_open),
    .ack_en     (ack_en),
    .ack_slot   (ack_slot),
    .ack_drive  (ack_drive)
  );

  // R7: request only for an accepted, non-broadcast frame
  a_r7_ack_directed: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> accept && !bcast);

  // R8: after close, nothing is accepted until a new header
  a_r8_closed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> !accept && !bcast);

  // R1: quiet outputs while the frame tracker is idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_open |-> !accept && !ack_drive);

endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_valid = 1'b0;
  logic        blk_hdr = 1'b0;
  logic        blk_eom = 1'b0;
  logic [7:0]  blk_byte = '0;
  logic        ack_slot = 1'b0;
  logic [14:0] own_mask = '0;
  logic        listen_all = 1'b0;
  logic        accept, ack_drive, bcast;
  logic [3:0]  init_addr, dest_addr;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_hdr(blk_hdr),
    .blk_eom(blk_eom), .blk_byte(blk_byte), .ack_slot(ack_slot),
    .own_mask(own_mask), .listen_all(listen_all), .accept(accept),
    .ack_drive(ack_drive), .bcast(bcast), .init_addr(init_addr),
    .dest_addr(dest_addr)
  );

  // {mask[14:0], listen, header[7:0], exp_accept, exp_bcast, exp_ack}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {15'h0001, 1'b0, 8'h40, 3'b101},
    {15'h0001, 1'b0, 8'h41, 3'b000},
    {15'h0001, 1'b1, 8'h41, 3'b100},
    {15'h0000, 1'b0, 8'h30, 3'b000},
    {15'h0000, 1'b1, 8'h30, 3'b100},
    {15'h4000, 1'b0, 8'h2E, 3'b101},
    {15'h4000, 1'b0, 8'h2D, 3'b000},
    {15'h0005, 1'b0, 8'h12, 3'b101},
    {15'h0005, 1'b0, 8'h11, 3'b000},
    {15'h7FFF, 1'b0, 8'h5F, 3'b110},
    {15'h0000, 1'b0, 8'h0F, 3'b110},
    {15'h0000, 1'b1, 8'hFF, 3'b110},
    {15'h7FFF, 1'b1, 8'h3E, 3'b101},
    {15'h0200, 1'b1, 8'hA9, 3'b101}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one block; returns at the negedge after it was captured
  task automatic blk(input logic [7:0] b, input logic hdr, input logic eom);
    @(negedge clk);
    blk_valid = 1'b1; blk_hdr = hdr; blk_eom = eom; blk_byte = b;
    @(negedge clk);
    blk_valid = 1'b0; blk_hdr = 1'b0; blk_eom = 1'b0;
  endtask

  // acknowledge slot of one cycle; returns at the negedge after its fall was seen
  task automatic slot(input string tag, input logic exp_ack);
    ack_slot = 1'b1;
    #1 chk(tag, 16'(ack_drive), 16'(exp_ack));
    @(negedge clk);
    ack_slot = 1'b0;
    @(negedge clk);
  endtask

  logic [26:0] v;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset accept", 16'(accept), 16'd0);
    chk("R1 reset ack", 16'(ack_drive), 16'd0);
    chk("R1 reset bcast", 16'(bcast), 16'd0);
    chk("R1 reset addrs", {8'd0, init_addr, dest_addr}, 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      @(negedge clk);
      own_mask = v[26:12]; listen_all = v[11];
      blk(v[10:3], 1'b1, 1'b1);
      chk("R4 R5 accept", 16'(accept), 16'(v[2]));
      chk("R6 bcast", 16'(bcast), 16'(v[1]));
      chk("R2 init", 16'(init_addr), 16'(v[10:7]));
      chk("R2 dest", 16'(dest_addr), 16'(v[6:3]));
      slot("R3 R7 ack in slot", v[0]);
      chk("R8 ping closed", {14'd0, accept, bcast}, 16'd0);
    end

    // R7 R8: multi-block owned frame, ack in every slot, closes only after eom
    own_mask = 15'h0008; listen_all = 1'b0;
    blk(8'h13, 1'b1, 1'b0);
    chk("R7 no ack outside slot", 16'(ack_drive), 16'd0);
    slot("R7 header slot", 1'b1);
    chk("R8 open after header", 16'(accept), 16'd1);
    blk(8'hA5, 1'b0, 1'b0);
    slot("R7 payload slot", 1'b1);
    chk("R8 still open", 16'(accept), 16'd1);
    chk("R2 dest held", 16'(dest_addr), 16'd3);
    blk(8'h5A, 1'b0, 1'b1);
    slot("R7 last slot", 1'b1);
    chk("R8 closed after eom", 16'(accept), 16'd0);
    chk("R8 addrs cleared", {8'd0, init_addr, dest_addr}, 16'd0);

    // R9: mask and mode changed mid-frame on an owned frame
    blk(8'h13, 1'b1, 1'b0);
    own_mask = 15'h0000; listen_all = 1'b1;
    slot("R9 ack kept", 1'b1);
    blk(8'h00, 1'b0, 1'b1);
    chk("R9 accept kept", 16'(accept), 16'd1);
    slot("R9 ack kept last", 1'b1);

    // R9: foreign frame in reduced mode, mode switched mid-frame
    own_mask = 15'h0008; listen_all = 1'b0;
    blk(8'h15, 1'b1, 1'b0);
    listen_all = 1'b1;
    slot("R9 no ack foreign", 1'b0);
    blk(8'h00, 1'b0, 1'b1);
    chk("R9 foreign stays rejected", 16'(accept), 16'd0);
    slot("R9 no ack last", 1'b0);

    // R10: second header while the frame is still open
    listen_all = 1'b0;
    blk(8'h13, 1'b1, 1'b0);
    chk("R10 first accepted", 16'(accept), 16'd1);
    blk(8'h24, 1'b1, 1'b1);
    chk("R10 restart accept", 16'(accept), 16'd0);
    chk("R10 restart dest", 16'(dest_addr), 16'd4);
    slot("R10 restart no ack", 1'b0);
    chk("R10 closed", 16'(accept), 16'd0);

    // R1: reset in the middle of an open frame
    blk(8'h13, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-frame reset accept", 16'(accept), 16'd0);
    ack_slot = 1'b1;
    #1 chk("R1 mid-frame reset ack", 16'(ack_drive), 16'd0);
    @(negedge clk); ack_slot = 1'b0; rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule